// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block is the host-side engine for enhanced-mode transfers over a parallel cable. The host bus selects one of two transfer targets, an address target or a data target, and raises a one-cycle request with a read or write direction. The engine then runs the full cable handshake in hardware. It asserts the matching strobe, waits for the peripheral's wait line to rise, releases the strobe, and waits for the wait line to fall again. While this happens the host bus cycle is held pending, so one host access covers one complete cable transfer.

The 8-bit cable data path has an output bus, a separate output enable and an input bus. The output enable is raised only during write cycles, which lets several devices share one tri-state bus. Read data is sampled when the peripheral signals ready. A watchdog limits each transfer to a fixed number of clock cycles. If the limit is reached, the engine releases every strobe, ends the host cycle and sets a sticky timeout flag. In normal use the host first writes an address to the peripheral and then reads or writes data at that address.

The controller has four named states. IDLE waits for a request. STROBE holds the strobe until the synchronized wait line rises. RELEASE has the strobe released and waits for the wait line to fall. DONE lasts one cycle, ends the host access, and returns to IDLE. The transitions are: IDLE to STROBE on a request; STROBE to RELEASE when the wait line rises; RELEASE to DONE when the wait line falls; STROBE or RELEASE to DONE when the watchdog expires; DONE to IDLE always.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset: `astb_n`, `dstb_n` and `wr_n` are 1; `pd_oe`, `host_wait`, `host_done` and `tmo_flag` are 0; `host_rdata` is 0.
- R2: An address write (`host_sel_addr`=1, `host_write`=1) drives `astb_n` low, `wr_n` low and `pd_oe` high with `pd_out` equal to the request's `host_wdata`. `dstb_n` stays high for the whole transfer.
- R3: A data access (`host_sel_addr`=0) drives `dstb_n` low. `astb_n` stays high for the whole transfer.
- R4: The strobe stays low until the peripheral raises `pp_wait`. Once the strobe is released, the transfer completes only after `pp_wait` returns low. `pp_wait` passes through a two-stage synchronizer.
- R5: During a read, `pd_oe` stays 0 and `wr_n` stays 1. The `pd_in` value present while `pp_wait` is high appears on `host_rdata` by the `host_done` cycle and is held afterwards.
- R6: `host_wait` is 1 from the cycle after the request until the transfer ends. `host_done` is a single-cycle pulse that marks the end of the transfer.
- R7: If the peripheral never raises `pp_wait`, the strobe stays low for exactly WDOG_CYCLES cycles. The strobe is then released, `host_done` pulses, `tmo_flag` becomes 1, and `host_rdata` keeps its previous value.
- R8: `tmo_flag` stays 1 until `tmo_clr` is pulsed. A timeout in the same cycle as `tmo_clr` leaves the flag set.
- R9: A request raised while a transfer is in progress is ignored. It starts no second transfer and does not change the value being driven.
- R10: If the peripheral raises `pp_wait` but never lowers it, the watchdog still ends the transfer and sets `tmo_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle access request, sampled in IDLE |
| host_sel_addr | input | 1 | 1 selects the address target, 0 the data target |
| host_write | input | 1 | 1 write, 0 read |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Last byte read from the peripheral |
| host_wait | output | 1 | Host cycle stretch |
| host_done | output | 1 | One-cycle end-of-access pulse |
| tmo_clr | input | 1 | Clears the timeout flag |
| tmo_flag | output | 1 | Sticky timeout status |
| pd_out | output | 8 | Cable data output value |
| pd_oe | output | 1 | Cable data output enable |
| pd_in | input | 8 | Cable data input |
| astb_n | output | 1 | Address strobe, active low |
| dstb_n | output | 1 | Data strobe, active low |
| wr_n | output | 1 | Write direction, low on writes |
| pp_wait | input | 1 | Peripheral wait/ready handshake line |

## Verification
The assertions assume that the host issues a request only as a single-cycle pulse and holds `tmo_clr` low except when clearing. They also assume that `pp_wait` is at rest when reset is released. The bench's peripheral model raises `pp_wait` only after it sees a strobe, and lowers it only after the strobe is gone. It keeps `pd_in` stable while `pp_wait` is high. Deliberate faults, such as silence or a wait line stuck high, are produced by switching the model's mode. The host's request and clear lines are never driven by the model.

// File: rtl/epp_pkg.sv
package epp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RELEASE = 2'd2,
        ST_DONE    = 2'd3
    } epp_state_e;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!busy) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assign expire = busy && (cnt == CW'(LIMIT - 1));

    // the counter never runs past the limit while busy (R7)
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= CW'(LIMIT - 1)));
endmodule

// File: rtl/epp_fsm.sv
module epp_fsm
    import epp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic sel_addr_q,
    input  logic write_q,
    input  logic wait_s,
    input  logic expire,
    output logic load,
    output logic capture,
    output logic busy,
    output logic done,
    output logic astb_n,
    output logic dstb_n,
    output logic wr_n,
    output logic oe
);
    epp_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req) nxt = ST_STROBE;
            ST_STROBE:  if (expire) nxt = ST_DONE;
                        else if (wait_s) nxt = ST_RELEASE;
            ST_RELEASE: if (expire || !wait_s) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load    = (state == ST_IDLE) && req;
        busy    = (state == ST_STROBE) || (state == ST_RELEASE);
        done    = (state == ST_DONE);
        capture = (state == ST_STROBE) && wait_s && !expire && !write_q;
        astb_n  = !((state == ST_STROBE) && sel_addr_q);
        dstb_n  = !((state == ST_STROBE) && !sel_addr_q);
        wr_n    = !(busy && write_q);
        oe      = busy && write_q;
    end

    p_strobe_to_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && wait_s && !expire) |=> (state == ST_RELEASE));
    p_expire_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state == ST_DONE));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_ignores_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && !expire && !wait_s) |=> (state == ST_STROBE));
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine #(
    parameter int DW          = 8,
    parameter int WDOG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_sel_addr,
    input  logic          host_write,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_wait,
    output logic          host_done,
    input  logic          tmo_clr,
    output logic          tmo_flag,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic [DW-1:0] pd_in,
    output logic          astb_n,
    output logic          dstb_n,
    output logic          wr_n,
    input  logic          pp_wait
);
    logic          wait_s, expire, load, capture, busy, done;
    logic          sel_addr_q, write_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          tmo_q;

    epp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pp_wait), .dout(wait_s));

    epp_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .busy(busy), .expire(expire));

    epp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(host_req),
        .sel_addr_q(sel_addr_q), .write_q(write_q),
        .wait_s(wait_s), .expire(expire),
        .load(load), .capture(capture), .busy(busy), .done(done),
        .astb_n(astb_n), .dstb_n(dstb_n), .wr_n(wr_n), .oe(pd_oe));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_addr_q <= 1'b0;
            write_q    <= 1'b0;
            wdata_q    <= '0;
        end else if (load) begin
            sel_addr_q <= host_sel_addr;
            write_q    <= host_write;
            wdata_q    <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= pd_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tmo_q <= 1'b0;
        else if (expire)  tmo_q <= 1'b1;
        else if (tmo_clr) tmo_q <= 1'b0;
    end

    assign host_rdata = rdata_q;
    assign host_wait  = busy;
    assign host_done  = done;
    assign tmo_flag   = tmo_q;
    assign pd_out     = wdata_q;

    p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !tmo_clr) |=> tmo_flag);
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!astb_n && !dstb_n));
    p_oe_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_oe |-> !wr_n);
    p_done_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> $past(host_wait));
endmodule

// File: tb/test_epp_cycle_engine.sv
module test_epp_cycle_engine;
    localparam int WD = 32;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       host_req = 1'b0, host_sel_addr = 1'b0, host_write = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata, pd_out, pd_in = '0;
    logic       host_wait, host_done, tmo_clr = 1'b0, tmo_flag;
    logic       pd_oe, astb_n, dstb_n, wr_n, pp_wait = 1'b0;

    int tests = 0, fails = 0;
    int mode = 0;            // 0 normal, 1 silent, 2 wait stuck high
    logic [7:0] periph_byte = '0;
    logic [7:0] seen_out;
    logic seen_a, seen_d, seen_oe, seen_wrn, seen_other_strobe;
    int   strobes_seen, done_count, wait_cycles, strobe_cycles;

    always #10 clk = ~clk;

    epp_cycle_engine #(.WDOG_CYCLES(WD)) i_epp_cycle_engine (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_sel_addr(host_sel_addr),
        .host_write(host_write), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_wait(host_wait), .host_done(host_done), .tmo_clr(tmo_clr),
        .tmo_flag(tmo_flag), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .astb_n(astb_n), .dstb_n(dstb_n), .wr_n(wr_n), .pp_wait(pp_wait));

    // peripheral model and observer, on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!astb_n || !dstb_n) begin
                strobe_cycles++;
                seen_a   = !astb_n || seen_a;
                seen_d   = !dstb_n || seen_d;
                seen_out = pd_out;
                seen_oe  = pd_oe;
                seen_wrn = wr_n;
                if (!pp_wait && mode != 1) begin
                    pp_wait = 1'b1;
                    pd_in   = periph_byte;
                end
            end else if (pp_wait && mode != 2) begin
                pp_wait = 1'b0;
            end
            if (host_done) done_count++;
            if (host_wait) wait_cycles++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        seen_a = 0; seen_d = 0; seen_oe = 0; seen_wrn = 1; seen_out = '0;
        strobe_cycles = 0; done_count = 0; wait_cycles = 0;
    endtask

    // issue one access and wait until the done pulse
    task automatic access(input logic sel_addr, input logic wr, input logic [7:0] d,
                          input bit poke_busy);
        clear_obs();
        @(negedge clk);
        host_req = 1; host_sel_addr = sel_addr; host_write = wr; host_wdata = d;
        @(negedge clk);
        host_req = 0;
        check("R6 wait raised after request", host_wait, 1);
        if (poke_busy) begin
            host_req = 1; host_wdata = ~d; host_sel_addr = ~sel_addr;
            @(negedge clk);
            host_req = 0;
        end
        for (int i = 0; i < 400 && !host_done; i++) @(negedge clk);
        check("R6 done reached", host_done, 1);
        @(negedge clk);
        check("R6 done single pulse", host_done, 0);
        check("R6 wait dropped", host_wait, 0);
    endtask

    task automatic t_reset();
        check("R1 astb_n", astb_n, 1);
        check("R1 dstb_n", dstb_n, 1);
        check("R1 wr_n", wr_n, 1);
        check("R1 pd_oe", pd_oe, 0);
        check("R1 host_wait", host_wait, 0);
        check("R1 host_done", host_done, 0);
        check("R1 tmo_flag", tmo_flag, 0);
        check("R1 host_rdata", host_rdata, 0);
    endtask

    task automatic t_addr_write();
        mode = 0;
        access(1, 1, 8'h5A, 0);
        check("R2 address strobe used", seen_a, 1);
        check("R2 data strobe idle", seen_d, 0);
        check("R2 output enabled", seen_oe, 1);
        check("R2 wr_n low", seen_wrn, 0);
        check("R2 byte driven", seen_out, 8'h5A);
        check("R4 strobe held through sync", strobe_cycles >= 3, 1);
        check("R4 wait line low at end", pp_wait, 0);
        check("R7 no timeout", tmo_flag, 0);
    endtask

    task automatic t_data_write();
        mode = 0;
        access(0, 1, 8'hC3, 0);
        check("R3 data strobe used", seen_d, 1);
        check("R3 address strobe idle", seen_a, 0);
        check("R3 byte driven", seen_out, 8'hC3);
    endtask

    task automatic t_data_read();
        mode = 0; periph_byte = 8'hA7;
        access(0, 0, 8'h00, 0);
        check("R5 output not enabled", seen_oe, 0);
        check("R5 wr_n high", seen_wrn, 1);
        check("R5 read byte", host_rdata, 8'hA7);
        periph_byte = 8'h11; pd_in = 8'h22;
        repeat (3) @(negedge clk);
        check("R5 read byte held", host_rdata, 8'hA7);
    endtask

    task automatic t_busy_req();
        mode = 0;
        access(1, 1, 8'h3C, 1);
        check("R9 original byte kept", seen_out, 8'h3C);
        check("R9 no data strobe", seen_d, 0);
        repeat (8) @(negedge clk);
        check("R9 single transfer", done_count, 1);
    endtask

    task automatic t_timeout_silent();
        mode = 1; periph_byte = 8'hEE;
        access(0, 0, 8'h00, 0);
        check("R7 strobe length", strobe_cycles, WD);
        check("R7 tmo_flag set", tmo_flag, 1);
        check("R7 rdata unchanged", host_rdata, 8'hA7);
        check("R7 strobes released", astb_n & dstb_n, 1);
        repeat (4) @(negedge clk);
        check("R8 flag sticky", tmo_flag, 1);
        tmo_clr = 1; @(negedge clk); tmo_clr = 0;
        check("R8 flag cleared", tmo_flag, 0);
    endtask

    task automatic t_timeout_stuck();
        mode = 2;
        access(1, 1, 8'h81, 0);
        check("R10 wait cycles bounded", wait_cycles, WD);
        check("R10 tmo_flag set", tmo_flag, 1);
        mode = 0; pp_wait = 0;
        repeat (4) @(negedge clk);
        tmo_clr = 1; @(negedge clk); tmo_clr = 0;
        check("R8 cleared again", tmo_flag, 0);
    endtask

    task automatic t_clear_vs_set();
        mode = 1;
        clear_obs();
        @(negedge clk);
        host_req = 1; host_sel_addr = 0; host_write = 1; host_wdata = 8'h01;
        @(negedge clk);
        host_req = 0;
        // strobe entered at the previous edge; expiry acts at edge WD from it
        repeat (WD - 1) @(negedge clk);
        check("R8 strobe still held before expiry", dstb_n, 0);
        tmo_clr = 1;
        @(negedge clk);
        tmo_clr = 0;
        check("R8 set wins over clear", tmo_flag, 1);
        check("R7 done at expiry", host_done, 1);
        mode = 0;
        repeat (3) @(negedge clk);
        tmo_clr = 1; @(negedge clk); tmo_clr = 0;
    endtask

    initial begin
        clear_obs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_addr_write();
        t_data_write();
        t_data_read();
        t_busy_req();
        t_timeout_silent();
        t_timeout_stuck();
        t_clear_vs_set();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule